// File: doc/BRIEF.md
# Dual-Channel External Interrupt Conditioner

This block turns two asynchronous port pins into interrupt-pending flags for a small processor core. Each of the two channels watches one pin out of a parameterised port (16 pins by default), chosen by its own select field. The watching is read-only, so whatever else uses that pin is not disturbed. Each pin passes through a two-flop synchroniser. A per-channel polarity bit then maps the sample to an active-high level. A per-channel sensitivity bit chooses between latched edge detection and live level following.

In edge mode the flag is set by an inactive-to-active transition. It stays set until the core acknowledges the vector for that channel or software writes the flag. If a new edge lands in the same cycle as an acknowledge, the edge wins. In level mode the flag mirrors the qualified input with no latching. As long as the source holds its line active, the request is raised again after service. Configuration and flags sit in three small byte-wide registers that share one address for read and write.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, every register reads 0x00, both channels are in level mode and active-low with pin select 0, and `irq_pend` is 0 while the selected pins are high.
- R2: Active-low level mode (polarity 0, mode 0): `irq_pend[c]` is 1 from the second rising clock edge after the selected pin goes low. It returns to 0 by the second edge after the pin goes high, with no latching.
- R3: Active-high level mode (polarity 1, mode 0): `irq_pend[c]` follows the selected pin directly, with the same two-edge latency.
- R4: Active-low edge mode (polarity 0, mode 1): a high-to-low change on the selected pin sets `irq_pend[c]` on the third rising edge after the change. The flag stays set after the pin goes high again.
- R5: Active-high edge mode (polarity 1, mode 1): a low-to-high change on the selected pin sets the flag with the same three-edge latency.
- R6: In edge mode, a one-cycle pulse on `vec_ack[c]` clears the flag at the next clock edge.
- R7: In edge mode, when a new active transition reaches the flag logic in the same cycle as `vec_ack[c]`, the flag ends up set.
- R8: With the channel already in edge mode, writing address 0 loads the pending flag from the data bit (bit 1 for channel 0, bit 3 for channel 1). In level mode, that write has no effect on the flag and the flag still shows the live input.
- R9: The channel-0 select is address 1 bits [3:0] and the channel-1 select is bits [7:4]. Each chooses which pin drives its channel, and pins that are not selected have no effect.
- R10: Register map readback: address 0 holds mode bits at 0 (ch0) and 2 (ch1) and pending flags at 1 (ch0) and 3 (ch1). Address 1 holds the selects. Address 2 holds the polarity at bit 0 (ch0) and bit 1 (ch1). Address 3 reads 0.
- R11: The two channels are independent: activity, acknowledge or configuration on one never changes the other's flag.
- R12: In level mode, `vec_ack[c]` has no effect: the flag stays 1 while the input remains active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | NUM_PINS | Asynchronous port pins being watched |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| vec_ack | input | 2 | Per-channel vector acknowledge from the core |
| irq_pend | output | 2 | Per-channel interrupt-pending flags |

## Verification
The hardest situation to reach is the acknowledge colliding with a fresh edge. The acknowledge must land in the one cycle in which the new synchronised sample is active and the previous sample is not, and the flag must already be set, or the result proves nothing. The stimulus first leaves a latched flag from an earlier edge and lets the pin go inactive. It then raises the pin again at a falling clock edge, counts two rising edges through the synchroniser, and pulses the acknowledge for exactly the following cycle. A follow-up acknowledge on its own then shows that the flag really is clearable, so the survival is due to the collision.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int CH_NUM = 2;
   localparam int REG_W  = 8;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_PINSEL = 2'd1,
      REG_POL    = 2'd2,
      REG_RSVD   = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int   WIDTH   = 16,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ext_irq_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ext_irq_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{{WIDTH{RST_VAL}}}};
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan #(
   parameter int NUM_PINS = 16,
   parameter int SEL_W    = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_bus,
   input  logic [SEL_W-1:0]    sel,
   input  logic                act_high,
   input  logic                edge_mode,
   input  logic                ack,
   input  logic                flag_we,
   input  logic                flag_wd,
   output logic                pend
);
   logic pin_bit;
   logic act_lvl;
   logic prev_q;
   logic rise;
   logic flag_q;

   generate
      if ((1 << SEL_W) == NUM_PINS) begin : g_full_mux
         assign pin_bit = pin_bus[sel];
      end else begin : g_guard_mux
         assign pin_bit = (int'(sel) < NUM_PINS) ? pin_bus[sel] : 1'b0;
      end
   endgenerate

   assign act_lvl = pin_bit ^ ~act_high;
   assign rise    = act_lvl & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= act_lvl;
         if (!edge_mode)   flag_q <= 1'b0;
         else if (rise)    flag_q <= 1'b1;
         else if (flag_we) flag_q <= flag_wd;
         else if (ack)     flag_q <= 1'b0;
      end
   end

   assign pend = edge_mode ? flag_q : act_lvl;

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && rise) |=> flag_q);
   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && ack && !rise && !flag_we) |=> !flag_q);
   assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && flag_we && !rise) |=> (flag_q == $past(flag_wd)));
   assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && !rise && !ack && !flag_we) |=> $stable(flag_q));
   assert_no_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode |=> !flag_q);
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins,
   input  logic                wr_en,
   input  logic [1:0]          addr,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   input  logic [CH_NUM-1:0]   vec_ack,
   output logic [CH_NUM-1:0]   irq_pend
);
   localparam int SEL_FIELD = REG_W / CH_NUM;

   generate
      if (NUM_PINS < 2 || SEL_W > SEL_FIELD) begin : g_bad_pins
         $error("ext_irq_detect: NUM_PINS must be 2..16");
      end
   endgenerate

   reg_addr_e            reg_sel;
   logic [NUM_PINS-1:0]  pins_s;
   logic [CH_NUM-1:0]    mode_q;
   logic [CH_NUM-1:0]    pol_q;
   logic [SEL_W-1:0]     sel_q [CH_NUM];
   logic                 ctrl_we;

   assign reg_sel = reg_addr_e'(addr);
   assign ctrl_we = wr_en && (reg_sel == REG_CTRL);

   ext_irq_sync #(
      .WIDTH   (NUM_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins),
      .q     (pins_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         pol_q  <= '0;
         for (int c = 0; c < CH_NUM; c++) sel_q[c] <= '0;
      end else if (wr_en) begin
         for (int c = 0; c < CH_NUM; c++) begin
            case (reg_sel)
               REG_CTRL:   mode_q[c] <= wr_data[2*c];
               REG_PINSEL: sel_q[c]  <= wr_data[SEL_FIELD*c +: SEL_W];
               REG_POL:    pol_q[c]  <= wr_data[c];
               default:    ;
            endcase
         end
      end
   end

   genvar gc;
   generate
      for (gc = 0; gc < CH_NUM; gc++) begin : g_chan
         ext_irq_chan #(
            .NUM_PINS (NUM_PINS),
            .SEL_W    (SEL_W)
         ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_bus   (pins_s),
            .sel       (sel_q[gc]),
            .act_high  (pol_q[gc]),
            .edge_mode (mode_q[gc]),
            .ack       (vec_ack[gc]),
            .flag_we   (ctrl_we),
            .flag_wd   (wr_data[2*gc+1]),
            .pend      (irq_pend[gc])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      case (reg_sel)
         REG_CTRL: begin
            for (int c = 0; c < CH_NUM; c++) begin
               rd_data[2*c]   = mode_q[c];
               rd_data[2*c+1] = irq_pend[c];
            end
         end
         REG_PINSEL: begin
            for (int c = 0; c < CH_NUM; c++) rd_data[SEL_FIELD*c +: SEL_W] = sel_q[c];
         end
         REG_POL: rd_data[CH_NUM-1:0] = pol_q;
         default: rd_data = '0;
      endcase
   end

   assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == REG_RSVD) |-> (rd_data == '0));
endmodule

// File: tb/ext_irq_detect_tb_top.sv
`timescale 1ns/1ps
module ext_irq_detect_tb_top;
   localparam int NP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '1;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [7:0]    wr_data = 8'h00;
   logic [7:0]    rd_data;
   logic [1:0]    vec_ack = 2'b00;
   logic [1:0]    irq_pend;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ext_irq_detect #(.NUM_PINS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .vec_ack(vec_ack), .irq_pend(irq_pend)
   );

   // entry: sel0[27:24] pol0[23] sel1[22:19] pol1[18] pins[17:2] expected irq_pend[1:0]
   localparam int NV = 7;
   localparam logic [27:0] VEC [NV] = '{
      {4'd0,  1'b0, 4'd0, 1'b0, 16'hFFFF, 2'b00},
      {4'd0,  1'b0, 4'd5, 1'b0, 16'hFFFE, 2'b01},
      {4'd3,  1'b1, 4'd5, 1'b1, 16'h0008, 2'b01},
      {4'd3,  1'b1, 4'd5, 1'b1, 16'h0020, 2'b10},
      {4'd15, 1'b0, 4'd9, 1'b1, 16'h7FFF, 2'b11},
      {4'd15, 1'b1, 4'd9, 1'b0, 16'h7FFF, 2'b00},
      {4'd2,  1'b0, 4'd2, 1'b1, 16'hFFFB, 2'b01}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic pulse_ack(input logic [1:0] m);
      @(negedge clk);
      vec_ack = m;
      @(negedge clk);
      vec_ack = 2'b00;
   endtask

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(3);
      // R1 reset state
      rd_chk("R1 ctrl", 2'd0, 8'h00);
      rd_chk("R1 pinsel", 2'd1, 8'h00);
      rd_chk("R1 pol", 2'd2, 8'h00);
      chk("R1 irq", {6'd0, irq_pend}, 8'h00);

      // level-mode table: R2 R3 R9 R11
      for (int v = 0; v < NV; v++) begin
         wr(2'd1, {VEC[v][22:19], VEC[v][27:24]});
         wr(2'd2, {6'd0, VEC[v][18], VEC[v][23]});
         pins = VEC[v][17:2];
         ticks(3);
         chk("R2/R3/R9/R11 table", {6'd0, irq_pend}, {6'd0, VEC[v][1:0]});
      end

      // R2 latency and no latching, active-low, ch0 on pin 0
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h02);
      pins = 16'hFFFD;
      ticks(3);
      @(negedge clk); pins = 16'hFFFC;
      ticks(1);
      chk("R2 one edge not yet", {7'd0, irq_pend[0]}, 8'h00);
      ticks(1);
      chk("R2 level seen", {7'd0, irq_pend[0]}, 8'h01);
      pins = 16'hFFFD;
      ticks(3);
      chk("R2 no latch", {7'd0, irq_pend[0]}, 8'h00);

      // edge mode both channels
      wr(2'd0, 8'h05);
      ticks(2);
      chk("R4 edge idle", {6'd0, irq_pend}, 8'h00);
      @(negedge clk); pins = 16'hFFFC;
      ticks(2);
      chk("R4 two edges not yet", {7'd0, irq_pend[0]}, 8'h00);
      ticks(1);
      chk("R4 falling edge sets", {7'd0, irq_pend[0]}, 8'h01);
      pins = 16'hFFFD;
      ticks(4);
      chk("R4 flag latched", {7'd0, irq_pend[0]}, 8'h01);
      pulse_ack(2'b01);
      chk("R6 ack clears", {7'd0, irq_pend[0]}, 8'h00);
      rd_chk("R10 ctrl after ack", 2'd0, 8'h05);

      // R5 rising edge on ch1 (pin 1, active-high)
      @(negedge clk); pins = 16'hFFFF;
      ticks(3);
      chk("R5 rising edge sets", {7'd0, irq_pend[1]}, 8'h01);
      chk("R11 ch0 untouched", {7'd0, irq_pend[0]}, 8'h00);
      pins = 16'hFFFD;
      ticks(4);
      chk("R5 flag latched", {7'd0, irq_pend[1]}, 8'h01);

      // R7 edge and ack in the same cycle, flag already set
      @(negedge clk); pins = 16'hFFFF;
      @(negedge clk);
      @(negedge clk); vec_ack = 2'b10;
      @(negedge clk); vec_ack = 2'b00;
      chk("R7 set wins over ack", {7'd0, irq_pend[1]}, 8'h01);
      pulse_ack(2'b10);
      chk("R6 lone ack clears ch1", {7'd0, irq_pend[1]}, 8'h00);

      // R8 software writes in edge mode
      wr(2'd0, 8'h07);
      chk("R8 write sets ch0", {6'd0, irq_pend}, 8'h01);
      wr(2'd0, 8'h0D);
      chk("R8 write clears ch0 sets ch1", {6'd0, irq_pend}, 8'h02);
      wr(2'd0, 8'h05);
      rd_chk("R8 readback", 2'd0, 8'h05);

      // R8 level-mode write ignored; ch1 level active-high pin1=1 -> live 1
      wr(2'd0, 8'h02);
      chk("R8 level write ignored", {6'd0, irq_pend}, 8'h02);
      rd_chk("R10 ctrl level", 2'd0, 8'h08);

      // R12 ack in level mode has no effect
      pulse_ack(2'b10);
      ticks(1);
      chk("R12 level ack ignored", {7'd0, irq_pend[1]}, 8'h01);

      // R10 readback
      rd_chk("R10 pinsel", 2'd1, 8'h10);
      rd_chk("R10 pol", 2'd2, 8'h02);
      rd_chk("R10 reserved", 2'd3, 8'h00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule